// File: doc/BRIEF.md
# Single-Dword Completer Request Bridge

This block sits behind the receive side of a PCI Express style transaction layer. It takes memory request headers, each with at most one dword of write payload, and turns the requests that are exactly one dword long into single transactions on a 32-bit Avalon-MM master port. Each read gets a completion, which goes to a separate transmit path through a ready/valid completion port. A read returns data. An oversized read returns an abort status and makes no bus access.

The bridge handles strictly one request at a time.

- **Writes** are posted. The request port reopens as soon as the bus has accepted the write. An oversized write is accepted and thrown away at once.
- **Reads** keep the request port closed until the transmit side has taken the matching completion.

The Avalon-MM address is built from the request address. The upper bits are replaced by a fixed window base. The dword offset inside a power-of-two window is kept.

Top module: `sdw_req_bridge`

## Requirements
- R1: A memory read with length field equal to 1 (`req_is_write`=0) produces exactly one Avalon-MM read. It is then answered by one completion with `cpl_status`=3'b000 and `cpl_has_data`=1.
- R2: A memory write with length field equal to 1 (`req_is_write`=1) produces exactly one Avalon-MM write carrying `req_wdata`. It produces no completion.
- R3: A read whose length field is not 1 (including 0) makes no Avalon-MM access. It is answered by a completion with `cpl_status`=3'b100, `cpl_has_data`=0 and `cpl_data`=0.
- R4: A write whose length field is not 1 is accepted and discarded. It makes no Avalon-MM access and no completion, and `req_ready` is high again on the cycle after acceptance.
- R5: From acceptance until a request is fully processed, `req_ready` stays low. For a read this lasts until the cycle after the completion handshake (`cpl_valid` and `cpl_ready` both high).
- R6: While `avm_waitrequest` is high, an active `avm_read` or `avm_write` stays asserted with `avm_address`, `avm_byteenable` and `avm_writedata` unchanged. Read and write are never asserted together.
- R7: The four byte enables of the request appear unchanged on `avm_byteenable` for reads and writes. All 16 patterns are legal, including 4'b0000.
- R8: `avm_address` equals `WIN_BASE` with the low `WIN_BITS` bits cleared, OR the request address bits [`WIN_BITS`-1:2], with bits [1:0] zero.
- R9: A completion carries the request's requester ID and tag. Its 7-bit lower address is request address bits [6:2] followed by the byte index of the lowest set byte enable (bit 0 = index 0); an all-zero enable gives index 0. Fields hold while `cpl_valid` is high and `cpl_ready` is low.
- R10: The data of a successful read completion is `avm_readdata` from the first cycle `avm_readdatavalid` is high after the read was accepted.
- R11: After a one-dword write is accepted by the bus (`avm_write` high, `avm_waitrequest` low), `req_ready` is high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can accept a request |
| req_is_write | input | 1 | 1 = memory write, 0 = memory read |
| req_len | input | LEN_W | Length field in dwords |
| req_addr | input | REQ_AW | Request byte address |
| req_be | input | 4 | Byte enables of the dword |
| req_rid | input | RID_W | Requester ID |
| req_tag | input | TAG_W | Request tag |
| req_wdata | input | 32 | Write payload |
| avm_address | output | AVM_AW | Translated bus address |
| avm_read | output | 1 | Read strobe |
| avm_write | output | 1 | Write strobe |
| avm_byteenable | output | 4 | Byte enables |
| avm_writedata | output | 32 | Write data |
| avm_readdata | input | 32 | Read data |
| avm_readdatavalid | input | 1 | Read data valid |
| avm_waitrequest | input | 1 | Slave stall |
| cpl_valid | output | 1 | Completion present |
| cpl_ready | input | 1 | Transmit side takes completion |
| cpl_status | output | 3 | 3'b000 success, 3'b100 abort |
| cpl_has_data | output | 1 | Completion carries data |
| cpl_rid | output | RID_W | Requester ID echoed |
| cpl_tag | output | TAG_W | Tag echoed |
| cpl_lowaddr | output | 7 | Lower address field |
| cpl_data | output | 32 | Completion data |

## Verification
**Bus strobes.** The bus strobe rises on the cycle after a request is accepted and stays up for every cycle the slave stalls.

**Completions.**
- A read completion becomes valid one cycle after the first `avm_readdatavalid`.
- An abort completion becomes valid one cycle after acceptance.

**Request port.** `req_ready` comes back one cycle after the write handshake, the completion handshake or the acceptance of a dropped write.

**How the bench samples.** A monitor samples on falling clock edges. It settles each handshake against queued expectations when both handshake signals are high at that edge. It checks the ready return exactly one falling edge after the triggering handshake, so each result is judged in the cycle it is due.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ISSUE,
    ST_RD_WAIT,
    ST_WR_ISSUE,
    ST_CPL
  } sdw_state_e;

  typedef enum logic [1:0] {
    ACT_READ,
    ACT_WRITE,
    ACT_ABORT,
    ACT_DROP
  } sdw_action_e;

  localparam logic [2:0] CPL_SUCCESS = 3'b000;
  localparam logic [2:0] CPL_ABORT   = 3'b100;

  // byte index of the lowest enabled byte, 0 when none is enabled
  function automatic logic [1:0] first_byte(input logic [3:0] be);
    if (be[0])      first_byte = 2'd0;
    else if (be[1]) first_byte = 2'd1;
    else if (be[2]) first_byte = 2'd2;
    else if (be[3]) first_byte = 2'd3;
    else            first_byte = 2'd0;
  endfunction

endpackage

// File: rtl/sdw_req_classify.sv
module sdw_req_classify
  import sdw_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic             is_write,
  input  logic [LEN_W-1:0] len,
  input  logic [3:0]       be,
  input  logic [4:0]       addr_dw,
  output sdw_action_e      action,
  output logic [6:0]       low_addr
);

  localparam logic [LEN_W-1:0] ONE_DW = LEN_W'(1);

  logic single;
  assign single = (len == ONE_DW);

  always_comb begin
    if (is_write) action = single ? ACT_WRITE : ACT_DROP;
    else          action = single ? ACT_READ  : ACT_ABORT;
  end

  assign low_addr = {addr_dw, first_byte(be)};

endmodule

// File: rtl/sdw_addr_xlate.sv
module sdw_addr_xlate #(
  parameter int                IN_AW    = 32,
  parameter int                OUT_AW   = 32,
  parameter int                WIN_BITS = 12,
  parameter logic [OUT_AW-1:0] WIN_BASE = '0
) (
  input  logic [IN_AW-1:0]  in_addr,
  output logic [OUT_AW-1:0] out_addr
);

  localparam int OFS_W = WIN_BITS - 2;

  logic [OFS_W-1:0] dw_ofs;
  logic             unused_bits;

  assign dw_ofs      = in_addr[WIN_BITS-1:2];
  assign unused_bits = ^{in_addr[IN_AW-1:WIN_BITS], in_addr[1:0]};
  assign out_addr    = {WIN_BASE[OUT_AW-1:WIN_BITS], dw_ofs, 2'b00};

endmodule

// File: rtl/sdw_cpl_reg.sv
module sdw_cpl_reg
  import sdw_pkg::*;
#(
  parameter int RID_W = 16,
  parameter int TAG_W = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [2:0]       ld_status,
  input  logic             ld_has_data,
  input  logic [RID_W-1:0] ld_rid,
  input  logic [TAG_W-1:0] ld_tag,
  input  logic [6:0]       ld_lowaddr,
  input  logic [DW-1:0]    ld_data,
  output logic             cpl_valid,
  input  logic             cpl_ready,
  output logic [2:0]       cpl_status,
  output logic             cpl_has_data,
  output logic [RID_W-1:0] cpl_rid,
  output logic [TAG_W-1:0] cpl_tag,
  output logic [6:0]       cpl_lowaddr,
  output logic [DW-1:0]    cpl_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cpl_valid    <= 1'b0;
      cpl_status   <= CPL_SUCCESS;
      cpl_has_data <= 1'b0;
      cpl_rid      <= '0;
      cpl_tag      <= '0;
      cpl_lowaddr  <= '0;
      cpl_data     <= '0;
    end else if (load) begin
      cpl_valid    <= 1'b1;
      cpl_status   <= ld_status;
      cpl_has_data <= ld_has_data;
      cpl_rid      <= ld_rid;
      cpl_tag      <= ld_tag;
      cpl_lowaddr  <= ld_lowaddr;
      cpl_data     <= ld_data;
    end else if (cpl_valid && cpl_ready) begin
      cpl_valid    <= 1'b0;
    end
  end

  AST_CPL_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    load |-> !cpl_valid); // R5
  AST_CPL_HOLD: assert property (@(posedge clk) disable iff (rst)
    cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_rid) && $stable(cpl_tag)
      && $stable(cpl_lowaddr) && $stable(cpl_data) && $stable(cpl_status)); // R9
  AST_ABORT_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    cpl_valid && (cpl_status == CPL_ABORT) |-> !cpl_has_data && (cpl_data == '0)); // R3

endmodule

// File: rtl/sdw_req_bridge.sv
module sdw_req_bridge
  import sdw_pkg::*;
#(
  parameter int                REQ_AW   = 32,
  parameter int                AVM_AW   = 32,
  parameter int                LEN_W    = 10,
  parameter int                RID_W    = 16,
  parameter int                TAG_W    = 8,
  parameter int                WIN_BITS = 12,
  parameter logic [AVM_AW-1:0] WIN_BASE = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_write,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [REQ_AW-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [RID_W-1:0]  req_rid,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [31:0]       req_wdata,
  output logic [AVM_AW-1:0] avm_address,
  output logic              avm_read,
  output logic              avm_write,
  output logic [3:0]        avm_byteenable,
  output logic [31:0]       avm_writedata,
  input  logic [31:0]       avm_readdata,
  input  logic              avm_readdatavalid,
  input  logic              avm_waitrequest,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic [2:0]        cpl_status,
  output logic              cpl_has_data,
  output logic [RID_W-1:0]  cpl_rid,
  output logic [TAG_W-1:0]  cpl_tag,
  output logic [6:0]        cpl_lowaddr,
  output logic [31:0]       cpl_data
);

  localparam int DW   = 32;
  localparam int LA_W = 7;

  sdw_state_e          state;
  sdw_action_e         action;
  logic [LA_W-1:0]     req_lowaddr;
  logic [AVM_AW-1:0]   xl_addr;
  logic                accept;

  // request context kept for the completion
  logic [RID_W-1:0]    ctx_rid;
  logic [TAG_W-1:0]    ctx_tag;
  logic [LA_W-1:0]     ctx_lowaddr;

  // completion load bus
  logic                cpl_load;
  logic [2:0]          cpl_ld_status;
  logic                cpl_ld_has_data;
  logic [RID_W-1:0]    cpl_ld_rid;
  logic [TAG_W-1:0]    cpl_ld_tag;
  logic [LA_W-1:0]     cpl_ld_lowaddr;
  logic [DW-1:0]       cpl_ld_data;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  sdw_req_classify #(.LEN_W(LEN_W)) i_classify (
    .is_write (req_is_write),
    .len      (req_len),
    .be       (req_be),
    .addr_dw  (req_addr[6:2]),
    .action   (action),
    .low_addr (req_lowaddr)
  );

  sdw_addr_xlate #(
    .IN_AW    (REQ_AW),
    .OUT_AW   (AVM_AW),
    .WIN_BITS (WIN_BITS),
    .WIN_BASE (WIN_BASE)
  ) i_xlate (
    .in_addr  (req_addr),
    .out_addr (xl_addr)
  );

  // completion source selection: abort straight from the request, success from the bus
  always_comb begin
    cpl_load        = 1'b0;
    cpl_ld_status   = CPL_SUCCESS;
    cpl_ld_has_data = 1'b0;
    cpl_ld_rid      = ctx_rid;
    cpl_ld_tag      = ctx_tag;
    cpl_ld_lowaddr  = ctx_lowaddr;
    cpl_ld_data     = '0;
    if (state == ST_IDLE && accept && action == ACT_ABORT) begin
      cpl_load       = 1'b1;
      cpl_ld_status  = CPL_ABORT;
      cpl_ld_rid     = req_rid;
      cpl_ld_tag     = req_tag;
      cpl_ld_lowaddr = req_lowaddr;
    end else if (state == ST_RD_WAIT && avm_readdatavalid) begin
      cpl_load        = 1'b1;
      cpl_ld_has_data = 1'b1;
      cpl_ld_data     = avm_readdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      avm_read       <= 1'b0;
      avm_write      <= 1'b0;
      avm_address    <= '0;
      avm_byteenable <= '0;
      avm_writedata  <= '0;
      ctx_rid        <= '0;
      ctx_tag        <= '0;
      ctx_lowaddr    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            ctx_rid     <= req_rid;
            ctx_tag     <= req_tag;
            ctx_lowaddr <= req_lowaddr;
            case (action)
              ACT_READ: begin
                avm_read       <= 1'b1;
                avm_address    <= xl_addr;
                avm_byteenable <= req_be;
                state          <= ST_RD_ISSUE;
              end
              ACT_WRITE: begin
                avm_write      <= 1'b1;
                avm_address    <= xl_addr;
                avm_byteenable <= req_be;
                avm_writedata  <= req_wdata;
                state          <= ST_WR_ISSUE;
              end
              ACT_ABORT: state <= ST_CPL;
              default:   state <= ST_IDLE;
            endcase
          end
        end
        ST_RD_ISSUE: begin
          if (!avm_waitrequest) begin
            avm_read <= 1'b0;
            state    <= ST_RD_WAIT;
          end
        end
        ST_RD_WAIT: begin
          if (avm_readdatavalid) state <= ST_CPL;
        end
        ST_WR_ISSUE: begin
          if (!avm_waitrequest) begin
            avm_write <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        ST_CPL: begin
          if (cpl_valid && cpl_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  sdw_cpl_reg #(.RID_W(RID_W), .TAG_W(TAG_W), .DW(DW)) i_cpl (
    .clk          (clk),
    .rst          (rst),
    .load         (cpl_load),
    .ld_status    (cpl_ld_status),
    .ld_has_data  (cpl_ld_has_data),
    .ld_rid       (cpl_ld_rid),
    .ld_tag       (cpl_ld_tag),
    .ld_lowaddr   (cpl_ld_lowaddr),
    .ld_data      (cpl_ld_data),
    .cpl_valid    (cpl_valid),
    .cpl_ready    (cpl_ready),
    .cpl_status   (cpl_status),
    .cpl_has_data (cpl_has_data),
    .cpl_rid      (cpl_rid),
    .cpl_tag      (cpl_tag),
    .cpl_lowaddr  (cpl_lowaddr),
    .cpl_data     (cpl_data)
  );

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(avm_read && avm_write)); // R6
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    avm_read && avm_waitrequest |=> avm_read && $stable(avm_address)
      && $stable(avm_byteenable)); // R6
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    avm_write && avm_waitrequest |=> avm_write && $stable(avm_address)
      && $stable(avm_byteenable) && $stable(avm_writedata)); // R6
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (rst)
    (avm_read || avm_write || cpl_valid) |-> !req_ready); // R5
  AST_WR_POSTED: assert property (@(posedge clk) disable iff (rst)
    avm_write && !avm_waitrequest |=> req_ready && !cpl_valid); // R11
  AST_CPL_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(cpl_valid) && cpl_has_data |-> $past(avm_readdatavalid)); // R10

endmodule

// File: tb/test_sdw_req_bridge.sv
module test_sdw_req_bridge;
  import sdw_pkg::*;

  localparam int          CLK_PERIOD = 10;
  localparam int          Q          = CLK_PERIOD / 4;
  localparam int          WIN_BITS   = 12;
  localparam logic [31:0] WIN_BASE   = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, req_is_write;
  logic [9:0]  req_len;
  logic [31:0] req_addr;
  logic [3:0]  req_be;
  logic [15:0] req_rid;
  logic [7:0]  req_tag;
  logic [31:0] req_wdata;
  logic [31:0] avm_address;
  logic        avm_read, avm_write;
  logic [3:0]  avm_byteenable;
  logic [31:0] avm_writedata, avm_readdata;
  logic        avm_readdatavalid, avm_waitrequest;
  logic        cpl_valid, cpl_ready, cpl_has_data;
  logic [2:0]  cpl_status;
  logic [15:0] cpl_rid;
  logic [7:0]  cpl_tag;
  logic [6:0]  cpl_lowaddr;
  logic [31:0] cpl_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdw_req_bridge #(.WIN_BITS(WIN_BITS), .WIN_BASE(WIN_BASE)) i_sdw_req_bridge (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_is_write(req_is_write),
    .req_len(req_len), .req_addr(req_addr), .req_be(req_be), .req_rid(req_rid),
    .req_tag(req_tag), .req_wdata(req_wdata),
    .avm_address(avm_address), .avm_read(avm_read), .avm_write(avm_write),
    .avm_byteenable(avm_byteenable), .avm_writedata(avm_writedata),
    .avm_readdata(avm_readdata), .avm_readdatavalid(avm_readdatavalid),
    .avm_waitrequest(avm_waitrequest),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_status(cpl_status),
    .cpl_has_data(cpl_has_data), .cpl_rid(cpl_rid), .cpl_tag(cpl_tag),
    .cpl_lowaddr(cpl_lowaddr), .cpl_data(cpl_data)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  typedef struct {
    bit          wr;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
  } avm_item_t;

  typedef struct {
    logic [2:0]  st;
    bit          hd;
    logic [15:0] rid;
    logic [7:0]  tag;
    logic [6:0]  la;
    logic [31:0] data;
  } cpl_item_t;

  avm_item_t avm_q[$];
  cpl_item_t cpl_q[$];

  function automatic logic [31:0] exp_addr(input logic [31:0] a);
    logic [31:0] m;
    m = (32'h1 << WIN_BITS) - 32'h1;
    return (WIN_BASE & ~m) | (a & m & 32'hFFFF_FFFC);
  endfunction

  function automatic logic [31:0] slave_data(input logic [31:0] a);
    return a ^ 32'h5A5A_C3C3;
  endfunction

  function automatic logic [1:0] low_idx(input logic [3:0] be);
    for (int i = 0; i < 4; i++) if (be[i]) return 2'(i);
    return 2'd0;
  endfunction

  // ---------------- slave and transmit-side models ----------------
  int wait_len = 0, rd_lat = 1, cpl_stall = 0;
  int hold_cnt, cpl_cnt, rd_cnt;
  bit rd_busy;
  logic [31:0] rd_addr;

  assign avm_waitrequest = (avm_read || avm_write) && (hold_cnt < wait_len);
  assign cpl_ready       = cpl_valid && (cpl_cnt >= cpl_stall);

  always @(posedge clk) begin
    if (rst) begin
      hold_cnt <= 0; cpl_cnt <= 0; rd_busy <= 1'b0; rd_cnt <= 0;
      avm_readdatavalid <= 1'b0; avm_readdata <= '0; rd_addr <= '0;
    end else begin
      if ((avm_read || avm_write) && avm_waitrequest) hold_cnt <= hold_cnt + 1;
      else hold_cnt <= 0;
      if (cpl_valid && !cpl_ready) cpl_cnt <= cpl_cnt + 1;
      else cpl_cnt <= 0;
      avm_readdatavalid <= 1'b0;
      if (rd_busy) begin
        if (rd_cnt == 0) begin
          avm_readdatavalid <= 1'b1;
          avm_readdata      <= slave_data(rd_addr);
          rd_busy           <= 1'b0;
        end else rd_cnt <= rd_cnt - 1;
      end
      if (avm_read && !avm_waitrequest) begin
        rd_busy <= 1'b1; rd_cnt <= rd_lat - 1; rd_addr <= avm_address;
      end
    end
  end

  // ---------------- monitor ----------------
  bit busy = 0, want_ready = 0, prev_stall = 0, mon_on = 0;
  logic        prev_rd, prev_wr;
  logic [31:0] prev_addr, prev_wd;
  logic [3:0]  prev_be;

  always @(negedge clk) begin
    if (mon_on) begin
      if (want_ready) begin
        check(req_ready == 1'b1, "R4/R5/R11", "ready one cycle after done", req_ready, 1);
        want_ready = 0;
      end
      if (busy && req_ready) check(0, "R5", "ready while busy", req_ready, 0);
      if (prev_stall) begin
        check(avm_read == prev_rd && avm_write == prev_wr && avm_address == prev_addr
              && avm_byteenable == prev_be && avm_writedata == prev_wd,
              "R6", "hold under waitrequest", avm_address, prev_addr);
      end
      prev_stall = (avm_read || avm_write) && avm_waitrequest;
      prev_rd = avm_read; prev_wr = avm_write; prev_addr = avm_address;
      prev_be = avm_byteenable; prev_wd = avm_writedata;
      if ((avm_read || avm_write) && !avm_waitrequest) begin
        if (avm_q.size() == 0) begin
          check(0, "R3/R4", "unexpected bus access", avm_address, 0);
        end else begin
          avm_item_t e;
          e = avm_q.pop_front();
          check(avm_write == e.wr, "R1/R2", "strobe kind", avm_write, e.wr);
          check(avm_address == e.addr, "R8", "address", avm_address, e.addr);
          check(avm_byteenable == e.be, "R7", "byteenable", avm_byteenable, e.be);
          if (e.wr) check(avm_writedata == e.data, "R2", "writedata", avm_writedata, e.data);
        end
        if (avm_write) begin busy = 0; want_ready = 1; end
      end
      if (cpl_valid && cpl_ready) begin
        if (cpl_q.size() == 0) begin
          check(0, "R2/R4", "unexpected completion", cpl_tag, 0);
        end else begin
          cpl_item_t c;
          c = cpl_q.pop_front();
          check(cpl_status == c.st, "R1/R3", "status", cpl_status, c.st);
          check(cpl_has_data == c.hd, "R1/R3", "has_data", cpl_has_data, c.hd);
          check(cpl_rid == c.rid && cpl_tag == c.tag, "R9", "rid/tag",
                {cpl_rid, cpl_tag}, {c.rid, c.tag});
          check(cpl_lowaddr == c.la, "R9", "lowaddr", cpl_lowaddr, c.la);
          check(cpl_data == c.data, "R10", "data", cpl_data, c.data);
        end
        busy = 0; want_ready = 1;
      end
      if (req_valid && req_ready) begin
        if (req_is_write && req_len != 10'd1) want_ready = 1;
        else busy = 1;
      end
    end
  end

  // ---------------- driver ----------------
  task automatic send(input bit wr, input logic [9:0] len, input logic [31:0] addr,
                      input logic [3:0] be, input logic [15:0] rid, input logic [7:0] tag,
                      input logic [31:0] wd);
    bit single;
    single = (len == 10'd1);
    if (!wr) begin
      if (single) begin
        avm_q.push_back('{wr: 1'b0, addr: exp_addr(addr), be: be, data: 32'h0});
        cpl_q.push_back('{st: 3'b000, hd: 1'b1, rid: rid, tag: tag,
                          la: {addr[6:2], low_idx(be)}, data: slave_data(exp_addr(addr))});
      end else begin
        cpl_q.push_back('{st: 3'b100, hd: 1'b0, rid: rid, tag: tag,
                          la: {addr[6:2], low_idx(be)}, data: 32'h0});
      end
    end else if (single) begin
      avm_q.push_back('{wr: 1'b1, addr: exp_addr(addr), be: be, data: wd});
    end
    @(posedge clk); #Q;
    req_valid = 1'b1; req_is_write = wr; req_len = len; req_addr = addr;
    req_be = be; req_rid = rid; req_tag = tag; req_wdata = wd;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #Q;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while ((avm_q.size() != 0 || cpl_q.size() != 0 || busy || want_ready) && n < 500) begin
      @(negedge clk); n++;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    check(0, "R5", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_is_write = 1'b0; req_len = '0; req_addr = '0;
    req_be = '0; req_rid = '0; req_tag = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    #Q rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R5", "reset ready", req_ready, 1);
    check(avm_read == 1'b0 && avm_write == 1'b0, "R6", "reset strobes",
          {avm_read, avm_write}, 0);
    check(cpl_valid == 1'b0, "R9", "reset cpl_valid", cpl_valid, 0);
    mon_on = 1;

    // R1 R8 R10: plain single read
    send(0, 10'd1, 32'h1234_5678, 4'hF, 16'h0100, 8'h01, 32'h0);
    wait_idle();
    // R6 R7 R9: stalled read, middle byte enable, longer latency
    wait_len = 2; rd_lat = 3;
    send(0, 10'd1, 32'h0000_0ABC, 4'b0100, 16'h0200, 8'h02, 32'h0);
    wait_idle();
    // R2 R11: writes with and without stall
    wait_len = 0;
    send(1, 10'd1, 32'hFFFF_F004, 4'b0011, 16'h0300, 8'h03, 32'hDEAD_BEEF);
    wait_idle();
    wait_len = 3;
    send(1, 10'd1, 32'h0000_0FFC, 4'b1000, 16'h0301, 8'h04, 32'hCAFE_F00D);
    wait_idle();
    // R3: oversized reads, length 2 and length 0
    wait_len = 0; rd_lat = 1;
    send(0, 10'd2, 32'h0000_0040, 4'b0010, 16'h0400, 8'h05, 32'h0);
    send(0, 10'd0, 32'h0000_0063, 4'hF, 16'h0401, 8'h06, 32'h0);
    wait_idle();
    // R4: oversized write dropped
    send(1, 10'd4, 32'h0000_0100, 4'hF, 16'h0500, 8'h07, 32'h1111_2222);
    wait_idle();
    check(avm_q.size() == 0 && cpl_q.size() == 0, "R4", "dropped write left nothing", 0, 0);
    // R5 R9: transmit side stalls the completion
    cpl_stall = 3;
    send(0, 10'd1, 32'h0000_0008, 4'b1100, 16'h0600, 8'h08, 32'h0);
    wait_idle();
    // R7: zero byte enables on read and write
    cpl_stall = 0;
    send(0, 10'd1, 32'h0000_0010, 4'b0000, 16'h0700, 8'h09, 32'h0);
    send(1, 10'd1, 32'h0000_0014, 4'b0000, 16'h0701, 8'h0A, 32'h1357_9BDF);
    wait_idle();
    // back-to-back mix: write, read, dropped write, abort, read
    wait_len = 1; rd_lat = 2; cpl_stall = 1;
    send(1, 10'd1, 32'h0000_0200, 4'b0110, 16'h0800, 8'h0B, 32'h2468_ACE0);
    send(0, 10'd1, 32'h0000_0204, 4'b1110, 16'h0801, 8'h0C, 32'h0);
    send(1, 10'd3, 32'h0000_0208, 4'hF, 16'h0802, 8'h0D, 32'h0);
    send(0, 10'd8, 32'h0000_020C, 4'b1000, 16'h0803, 8'h0E, 32'h0);
    send(0, 10'd1, 32'h0000_0210, 4'b0001, 16'h0804, 8'h0F, 32'h0);
    wait_idle();
    check(avm_q.size() == 0, "R1/R2", "all bus accesses seen", avm_q.size(), 0);
    check(cpl_q.size() == 0, "R1/R3", "all completions seen", cpl_q.size(), 0);
    summary();
    $finish;
  end

endmodule